// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Interface

This block is the bus-facing half of a byte-addressed serial memory. It watches a two-wire bus (a clock line and an open-drain data line), oversampled by the system clock, and turns the bit stream into memory operations. A transfer opens with a control byte that carries a fixed device-type nibble, a three-bit chip select and a direction bit. Only the device whose three strap inputs match the chip select answers, so eight of them can share one bus.

A write transfer carries a two-byte target address and then data bytes. Each data byte leaves the block as a single-cycle write strobe. The address then steps within its 32-byte sector. A read transfer returns the byte at the current address and keeps streaming while the master acknowledges. The read address wraps from the top of the space to zero.

While the memory side reports a program cycle in progress, the block does not answer its own address. The storage array, protection logic and program timer are outside this block. The memory side returns read data combinationally for the address the block presents.

Top module: `twowire_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) begins a new control-byte reception from any state, including in the middle of a transfer. A rising data line while the clock line is high (STOP) returns the block to idle with the data line released.
- R2: The control byte is received MSB first as {type[3:0]=4'b1010, select[2:0], dir}. The block acknowledges it by pulling the data line low during the ninth clock only when the type matches and select equals `chip_sel`. On a mismatch it stays silent until the next START.
- R3: While `mem_busy` is high at the end of the control byte, the block gives no acknowledge, keeps the data line released and ignores the bytes that follow until the next START.
- R4: After a control byte with dir=0, the next two bytes are the address, high byte first. Bits [4:0] of the high byte become address bits [12:8] and its top three bits are ignored. Both address bytes are acknowledged.
- R5: Each further byte of a write transfer is acknowledged and produces exactly one single-cycle `mem_wr` pulse, with `mem_wdata` equal to the byte and `mem_addr` equal to its target address. Read transfers produce no write strobe.
- R6: After each written byte, only address bits [4:0] advance, wrapping from 31 to 0 while bits [12:5] stay fixed.
- R7: A control byte with dir=1 makes the block send the byte at the current address, MSB first. The data line changes only while the clock line is low, and it is released during the ninth clock.
- R8: When the master acknowledges a read byte, the next byte sent is the one at address+1, and address 8191 is followed by address 0.
- R9: When the master does not acknowledge a read byte, the block sends nothing more until a new START. The next read then begins at the address after the last byte sent.
- R10: The data line is only ever pulled low (`sda_oe`=1), and is released after reset and whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| chip_sel | input | 3 | Strap value compared with the control byte select field |
| mem_busy | input | 1 | Program cycle in progress; suppresses the address acknowledge |
| mem_addr | output | 13 | Current byte address presented to the memory |
| mem_rdata | input | 8 | Read data for `mem_addr`, combinational |
| mem_wr | output | 1 | Single-cycle write strobe |
| mem_wdata | output | 8 | Byte to write while `mem_wr` is high |

## Verification
The cases hardest to reach from the ports are the two address wraps. Both need an address near a boundary and then a run of consecutive bytes. The stimulus writes address 0x1FFD and streams five data bytes, so the sector wrap shows up in the write strobes. It then sets address 0x1FFE, issues a repeated START into a read, and acknowledges across the top of the space. A bus monitor flags any change of the slave's drive while the clock line is high. The bench also clocks a byte after a non-acknowledged read, to show that the slave has let go of the line.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } tw_state_e;
endpackage

// File: rtl/tw_line_cond.sv
module tw_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [7:0]        ld_data,
  input  logic              inc_full,
  input  logic              inc_sect,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ld_hi)    addr_d[ADDR_W-1:8] = ld_data[HI_W-1:0];
    if (ld_lo)    addr_d[7:0]        = ld_data;
    if (inc_full) addr_d             = addr_q + 1'b1;
    if (inc_sect) addr_d[SECT_W-1:0] = addr_q[SECT_W-1:0] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  // R6: a sector step never disturbs the upper address bits
  assert_sector_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_sect |=> addr_q[ADDR_W-1:SECT_W] == $past(addr_q[ADDR_W-1:SECT_W]));

  // R8: the read counter wraps from the top of the space to zero
  assert_full_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && addr_q == '1) |=> addr_q == '0);
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
  import tw_pkg::*;
#(
  parameter int         ADDR_W   = 13,
  parameter int         SECT_W   = 5,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        chip_sel,
  input  logic              mem_busy,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata
);
  localparam int CNT_W = 4;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  tw_line_cond #(.SYNC_STAGES(2)) u_line (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  tw_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ackph_q, ackph_d;
  logic [7:0]       sr_q, sr_d;
  logic             mack_q, mack_d;
  logic             oe_q, oe_d;
  logic             wr_q, wr_d;
  logic [7:0]       wdat_q, wdat_d;
  logic             ld_hi, ld_lo, inc_full;
  logic             sel_match;

  tw_addr_ctr #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_data(sr_q), .inc_full(inc_full), .inc_sect(wr_q), .addr_q(mem_addr)
  );

  assign sel_match = (sr_q[7:4] == DEV_TYPE) && (sr_q[3:1] == chip_sel) && !mem_busy;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    ackph_d  = ackph_q;
    sr_d     = sr_q;
    mack_d   = mack_q;
    oe_d     = oe_q;
    wr_d     = 1'b0;
    wdat_d   = wdat_q;
    ld_hi    = 1'b0;
    ld_lo    = 1'b0;
    inc_full = 1'b0;
    if (start_det) begin
      state_d = ST_CTRL;
      cnt_d   = '0;
      ackph_d = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      ackph_d = 1'b0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_RDATA: begin
          if (!ackph_q && scl_fall) begin
            if (cnt_q == CNT_W'(7)) begin
              ackph_d  = 1'b1;
              oe_d     = 1'b0;
              cnt_d    = '0;
              inc_full = 1'b1;
            end else begin
              sr_d  = {sr_q[6:0], 1'b0};
              oe_d  = ~sr_q[6];
              cnt_d = cnt_q + 1'b1;
            end
          end else if (ackph_q && scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (ackph_q && scl_fall) begin
            ackph_d = 1'b0;
            if (mack_q) begin
              sr_d  = mem_rdata;
              oe_d  = ~mem_rdata[7];
              cnt_d = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          if (scl_rise && !ackph_q && cnt_q < CNT_W'(8)) begin
            sr_d  = {sr_q[6:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && !ackph_q && cnt_q == CNT_W'(8)) begin
            cnt_d   = '0;
            ackph_d = 1'b1;
            oe_d    = 1'b1;
            if (state_q == ST_CTRL && !sel_match) begin
              ackph_d = 1'b0;
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end
            if (state_q == ST_AHI)   ld_hi = 1'b1;
            if (state_q == ST_ALO)   ld_lo = 1'b1;
            if (state_q == ST_WDATA) begin
              wr_d   = 1'b1;
              wdat_d = sr_q;
            end
          end else if (scl_fall && ackph_q) begin
            ackph_d = 1'b0;
            oe_d    = 1'b0;
            if (state_q == ST_CTRL) begin
              if (sr_q[0]) begin
                state_d = ST_RDATA;
                sr_d    = mem_rdata;
                oe_d    = ~mem_rdata[7];
              end else begin
                state_d = ST_AHI;
              end
            end else if (state_q == ST_AHI) begin
              state_d = ST_ALO;
            end else if (state_q == ST_ALO) begin
              state_d = ST_WDATA;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ackph_q <= 1'b0;
      sr_q    <= '0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ackph_q <= ackph_d;
      sr_q    <= sr_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
      wr_q    <= wr_d;
      wdat_q  <= wdat_d;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_wr    = wr_q;
  assign mem_wdata = wdat_q;

  // R1: START always reopens control-byte reception
  assert_start_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_det |=> state_q == ST_CTRL);

  // R1: STOP returns to idle with the line released
  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    stop_det |=> (state_q == ST_IDLE && !sda_oe));

  // R3: a busy memory side gets no acknowledge on the control byte
  assert_busy_silent_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_CTRL && scl_fall && !ackph_q && cnt_q == CNT_W'(8) && mem_busy && !start_det && !stop_det)
    |=> (!sda_oe && state_q == ST_IDLE));

  // R5: every write strobe lasts exactly one cycle
  assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wr |=> !mem_wr);

  // R7: the drive changes only while the synchronised clock line is low
  assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R10: nothing is driven while idle
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    state_q == ST_IDLE |-> !sda_oe);
endmodule

// File: tb/twowire_mem_slave_tb.sv
module twowire_mem_slave_tb;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_scl, m_sda;
  logic        sda_oe;
  logic        sda_bus;
  logic [2:0]  chip_sel;
  logic        mem_busy;
  logic [12:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_wr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_err = 0;
  int wr_cnt = 0;
  int viol = 0;
  logic [12:0] wa [0:15];
  logic [7:0]  wd [0:15];
  logic        prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b011};
  endfunction

  assign mem_rdata = pat(mem_addr);

  twowire_mem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .chip_sel(chip_sel), .mem_busy(mem_busy), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (rst_n && mem_wr) begin
      if (wr_cnt < 16) begin
        wa[wr_cnt] <= mem_addr;
        wd[wr_cnt] <= mem_wdata;
      end
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && m_scl) viol <= viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw();
    m_scl = 1'b1; qw();
    m_sda = 1'b0; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw();
    m_scl = 1'b1; qw();
    m_sda = 1'b1; qw();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw();
      m_scl = 1'b1; qw(); qw();
      m_scl = 1'b0; qw();
    end
    m_sda = 1'b1; qw();
    m_scl = 1'b1; qw();
    ack = ~sda_bus; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw();
      m_scl = 1'b1; qw();
      b[i] = sda_bus; qw();
      m_scl = 1'b0; qw();
    end
    m_sda = ~mack; qw();
    m_scl = 1'b1; qw(); qw();
    m_scl = 1'b0; qw();
    m_sda = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    bus_start();
    put_byte(8'hAA, a); chk(a, "R2 write ctrl ack", a, 1);
    put_byte(hi, a);    chk(a, "R4 high addr ack", a, 1);
    put_byte(lo, a);    chk(a, "R4 low addr ack", a, 1);
  endtask

  initial begin
    logic        a;
    logic [7:0]  b;
    logic [12:0] ea;
    int          base;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; chip_sel = 3'b101; mem_busy = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);
    chk(mem_wr == 1'b0, "R5 reset no strobe", mem_wr, 0);

    // R2: sweep every select value, only the strapped one answers
    for (int s = 0; s < 8; s++) begin
      bus_start();
      put_byte({4'b1010, 3'(s), 1'b0}, a);
      chk(a == (s == 5), "R2 select match", a, (s == 5));
      bus_stop();
      chk(sda_bus == 1'b1, "R1 stop releases", sda_bus, 1);
    end
    bus_start();
    put_byte({4'b1011, 3'b101, 1'b0}, a);
    chk(a == 1'b0, "R2 wrong type", a, 0);
    bus_stop();

    // R3: busy suppresses the acknowledge and the following bytes
    mem_busy = 1'b1;
    base = wr_cnt;
    bus_start();
    put_byte(8'hAA, a); chk(a == 1'b0, "R3 busy no ack", a, 0);
    put_byte(8'h00, a); chk(a == 1'b0, "R3 later byte ignored", a, 0);
    put_byte(8'h55, a); chk(a == 1'b0, "R3 later byte ignored", a, 0);
    bus_stop();
    mem_busy = 1'b0;
    chk(wr_cnt == base, "R3 no write while busy", wr_cnt - base, 0);

    // R4 R5 R6: upper bits of high byte ignored, sector wrap on writes
    base = wr_cnt;
    set_addr(8'hFF, 8'hFD);
    for (int k = 0; k < 5; k++) begin
      put_byte(8'h30 + 8'(k), a);
      chk(a, "R5 data ack", a, 1);
    end
    bus_stop();
    repeat (4) @(negedge clk);
    chk(wr_cnt - base == 5, "R5 strobe count", wr_cnt - base, 5);
    for (int k = 0; k < 5; k++) begin
      ea = {8'hFF, 5'(5'h1D + k)};
      chk(wa[base+k] == ea, "R6 write address", wa[base+k], ea);
      chk(wd[base+k] == 8'h30 + 8'(k), "R5 write data", wd[base+k], 8'h30 + k);
    end

    // R1 R8: repeated START into a read that crosses the top of the space
    base = wr_cnt;
    set_addr(8'h1F, 8'hFE);
    bus_start();
    put_byte(8'hAB, a); chk(a, "R1 repeated start read ack", a, 1);
    for (int k = 0; k < 4; k++) begin
      ea = 13'(13'h1FFE + k);
      get_byte(k != 3, b);
      chk(b == pat(ea), "R8 sequential rollover data", b, pat(ea));
    end
    // R9: after the NACK the slave leaves the line alone
    get_byte(1'b0, b);
    chk(b == 8'hFF, "R9 silent after nack", b, 8'hFF);
    bus_stop();

    // R9: current-address read resumes after the last byte sent
    bus_start();
    put_byte(8'hAB, a); chk(a, "R7 read ctrl ack", a, 1);
    get_byte(1'b0, b);
    chk(b == pat(13'h0002), "R9 current address", b, pat(13'h0002));
    bus_stop();

    // R7 R8: long sequential read sweep
    set_addr(8'h0A, 8'hE0);
    bus_start();
    put_byte(8'hAB, a); chk(a, "R7 read ctrl ack", a, 1);
    for (int k = 0; k < 64; k++) begin
      ea = 13'(13'h0AE0 + k);
      get_byte(k != 63, b);
      chk(b == pat(ea), "R7 sweep data", b, pat(ea));
    end
    bus_stop();
    chk(wr_cnt == base, "R5 no strobe on reads", wr_cnt - base, 0);
    chk(viol == 0, "R7 drive change with clock high", viol, 0);
    chk(sda_oe == 1'b0, "R10 idle release", sda_oe, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule